// File: doc/BRIEF.md
# Serial ROM Block Reader

This engine fetches a run of bytes from a serial read-only memory on a four-wire SPI link. The requester supplies a start address, a byte count and one mode bit. The mode bit sets three things together: the command code, whether an idle byte follows the address, and which clock divider is used. This way a plain read always runs at the slower serial clock and a fast read runs at the faster one.

Once a request is taken, the engine lowers chip select and sends the command and the 24-bit address, most significant bit first. In fast mode it then sends eight dummy clocks. After that it keeps clocking and collects the requested number of bytes. Bytes leave through a one-entry valid/ready output. When the consumer does not take a byte, the serial clock is held low partway through the next byte, so nothing is dropped.

After the final sample, chip select goes high again. It then stays high for a set number of system cycles before the engine accepts the next request.

Top module: `srom_read_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy is low and no byte is offered.
- R2: With the mode bit low, the command code 0x03 is sent, then the 24 address bits most significant first, with no dummy clocks. The returned bytes are the memory contents starting at the request address.
- R3: With the mode bit high, the command code 0x0B is sent, then the address, then eight clocks with data out held at 0, before any data is sampled.
- R4: Data out changes only while the serial clock is low. Data in is taken on the rising clock edge. The clock rests low whenever chip select is high.
- R5: Each clock high phase and each unstalled low phase lasts NORM_HALF system cycles in normal mode and FAST_HALF system cycles in fast mode.
- R6: A transaction produces exactly 32 + 8·len rising edges in normal mode, or 40 + 8·len in fast mode, and delivers exactly len bytes. A request with len = 0 is not accepted.
- R7: The address is sent only once per transaction, even when the stream runs past the top address 0xFFFFFF and continues from 0x000000.
- R8: The first rising clock edge comes one half period after chip select falls. No rising edge occurs while chip select is high.
- R9: While a byte is offered and not taken, the offered data stays stable. The clock is then held low just before the edge that would complete the next byte, and no data is lost.
- R10: Busy is high from acceptance until the deselect gap ends. A request made while busy is ignored. Chip select stays high for at least CS_GAP system cycles between transactions.
- R11: Chip select rises one half period after the last rising edge, together with the clock returning low, with no extra clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 24 | Start byte address |
| req_len | input | CNT_W | Number of bytes to read |
| req_fast | input | 1 | 1 = fast read with dummy byte and fast divider |
| busy | output | 1 | Transaction or deselect gap in progress |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | rd_data holds a byte not yet taken |
| rd_ready | input | 1 | Consumer takes the byte |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
If the header counter is off, the memory model sees a wrong command code or address, and the first returned byte is wrong. This is visible as soon as that byte is offered. If the byte counter or the last-byte detection is wrong, the rising-edge total and the byte count no longer match 32 or 40 plus 8·len once chip select rises. If the divider selection or the gap counter is wrong, the bench sees wrong high-phase lengths or a short deselect interval within that same transaction. A fault in the stall gating shows up as a rising edge counted during a held-off byte, or as a changed output byte, while the consumer holds off.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int ADDR_W = 24;
  localparam int CMD_W  = 8 + ADDR_W + 8;
  localparam logic [7:0] OP_NORMAL = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;

  typedef enum logic [1:0] {PH_IDLE, PH_XFER, PH_TAIL, PH_GAP} phase_t;

  function automatic logic [7:0] opcode_for(input logic fast);
    return fast ? OP_FAST : OP_NORMAL;
  endfunction

  // rising edges before the first data bit
  function automatic logic [5:0] header_bits(input logic fast);
    return fast ? 6'(CMD_W) : 6'(CMD_W - 8);
  endfunction

  // opcode, address, then a zero byte used as dummy or idle fill
  function automatic logic [CMD_W-1:0] command_word(input logic fast,
                                                    input logic [ADDR_W-1:0] addr);
    return {opcode_for(fast), addr, 8'h00};
  endfunction
endpackage

// File: rtl/srom_halftick.sv
module srom_halftick #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srom_txshift.sv
module srom_txshift #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sr;

  assign bit_out = sr[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/srom_rxbyte.sv
module srom_rxbyte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       din,
  output logic [7:0] byte_nxt
);
  logic [6:0] sr;

  assign byte_nxt = {sr, din};

  always_ff @(posedge clk) begin
    if (!rst_n)      sr <= '0;
    else if (sample) sr <= {sr[5:0], din};
  end
endmodule

// File: rtl/srom_read_host.sv
module srom_read_host
  import srom_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int HALF_W    = 8,
  parameter int NORM_HALF = 3,
  parameter int FAST_HALF = 1,
  parameter int CS_GAP    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic              req_fast,
  output logic              busy,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_W = $clog2(CS_GAP + 1);

  phase_t             state;
  logic               fast_r;
  logic [5:0]         hdr_left;
  logic               in_data;
  logic [2:0]         bit_idx;
  logic [CNT_W-1:0]   bytes_left;
  logic [GAP_W-1:0]   gap_cnt;
  logic [HALF_W-1:0]  half_sel;
  logic [7:0]         byte_nxt;
  logic               tick;

  // named internal events
  logic acc_evt, rise_evt, fall_evt, byte_evt, last_evt, stall_w, gap_done, run_w;

  assign busy     = (state != PH_IDLE);
  assign half_sel = fast_r ? HALF_W'(FAST_HALF) : HALF_W'(NORM_HALF);
  assign run_w    = (state == PH_XFER) || (state == PH_TAIL);
  assign acc_evt  = (state == PH_IDLE) && req_valid && (req_len != '0);
  assign stall_w  = (state == PH_XFER) && !spi_sck && in_data && (bit_idx == 3'd7)
                    && rd_valid && !rd_ready;
  assign rise_evt = (state == PH_XFER) && tick && !spi_sck && !stall_w;
  assign fall_evt = (state == PH_XFER) && tick && spi_sck;
  assign byte_evt = rise_evt && in_data && (bit_idx == 3'd7);
  assign last_evt = byte_evt && (bytes_left == CNT_W'(1));
  assign gap_done = (state == PH_GAP) && (gap_cnt == GAP_W'(CS_GAP - 1));

  srom_halftick #(.HW(HALF_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_w), .half(half_sel), .tick(tick)
  );

  srom_txshift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(acc_evt),
    .load_val(command_word(req_fast, req_addr)),
    .shift(fall_evt), .bit_out(spi_mosi)
  );

  srom_rxbyte u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rise_evt && in_data),
    .din(spi_miso), .byte_nxt(byte_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      spi_sck    <= 1'b0;
      spi_cs_n   <= 1'b1;
      fast_r     <= 1'b0;
      hdr_left   <= '0;
      in_data    <= 1'b0;
      bit_idx    <= '0;
      bytes_left <= '0;
      gap_cnt    <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (byte_evt) begin
        rd_data  <= byte_nxt;
        rd_valid <= 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end

      case (state)
        PH_IDLE: begin
          if (acc_evt) begin
            state      <= PH_XFER;
            spi_cs_n   <= 1'b0;
            fast_r     <= req_fast;
            hdr_left   <= header_bits(req_fast);
            in_data    <= 1'b0;
            bit_idx    <= '0;
            bytes_left <= req_len;
          end
        end
        PH_XFER: begin
          if (rise_evt) begin
            spi_sck <= 1'b1;
            if (!in_data) begin
              hdr_left <= hdr_left - 6'd1;
              if (hdr_left == 6'd1) in_data <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == 3'd7) bytes_left <= bytes_left - CNT_W'(1);
            end
            if (last_evt) state <= PH_TAIL;
          end else if (fall_evt) begin
            spi_sck <= 1'b0;
          end
        end
        PH_TAIL: begin
          if (tick) begin
            spi_sck  <= 1'b0;
            spi_cs_n <= 1'b1;
            gap_cnt  <= '0;
            state    <= PH_GAP;
          end
        end
        default: begin
          if (gap_done) state <= PH_IDLE;
          else          gap_cnt <= gap_cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/srom_read_host_chk.sv
module srom_read_host_chk #(
  parameter int CS_GAP = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       busy,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       stall_w
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          hi_cnt <= 16'(CS_GAP);
    else if (!spi_cs_n)                  hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)         hi_cnt <= hi_cnt + 16'd1;
  end

  assert_idle_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  assert_rise_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> !spi_cs_n);

  assert_cs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  assert_gap_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(CS_GAP)));

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_stall_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> !spi_sck);

  assert_cs_after_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_sck));
endmodule

bind srom_read_host srom_read_host_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .stall_w(stall_w)
);

// File: tb/sim_srom_read_host.sv
`timescale 1ns/1ps
module sim_srom_read_host;
  localparam int NH = 3;
  localparam int FH = 1;
  localparam int GAP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic req_fast = 1'b0;
  logic busy;
  logic [7:0] rd_data;
  logic rd_valid;
  logic rd_ready = 1'b1;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  srom_read_host #(.CNT_W(16), .HALF_W(8), .NORM_HALF(NH), .FAST_HALF(FH), .CS_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_fast(req_fast), .busy(busy), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] romf(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  // memory model
  int m_rises = 0;
  logic [39:0] m_cmd = '0;
  logic [7:0] m_op = '0;
  logic [23:0] m_addr = '0;
  logic [7:0] m_dummy = 8'hFF;

  always @(negedge spi_cs_n) begin
    m_rises = 0; m_cmd = '0; m_op = '0; m_dummy = 8'hFF; spi_miso = 1'b0;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (m_rises < 40) m_cmd = {m_cmd[38:0], spi_mosi};
    m_rises++;
    if (m_rises == 8) m_op = m_cmd[7:0];
    if (m_rises == 32) m_addr = m_cmd[23:0];
    if (m_rises == 40 && m_op == 8'h0B) m_dummy = m_cmd[7:0];
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    int hdr;
    int k;
    logic [23:0] a;
    hdr = (m_op == 8'h0B) ? 40 : 32;
    if (m_rises >= hdr) begin
      k = m_rises - hdr;
      a = m_addr + 24'(k / 8);
      spi_miso = romf(a)[7 - (k % 8)];
    end
  end

  // port monitor and consumer
  int sess = 0, rises = 0, pre_rise = 0, last_hi = 0, hi_run = 0;
  int hi_min = 999, hi_max = 0, gap_run = 1000, gap_min = 1000;
  int mosi_bad = 0, idle_bad = 0, n_got = 0;
  bit seen_rise = 1'b0;
  logic sck_q = 1'b0, cs_q = 1'b1, mosi_q = 1'b0;
  logic [7:0] got [0:31];

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_q && !spi_cs_n) begin
        sess++; rises = 0; pre_rise = 0; seen_rise = 1'b0;
        hi_min = 999; hi_max = 0;
        if (gap_run < gap_min) gap_min = gap_run;
      end
      if (spi_cs_n) gap_run++; else gap_run = 0;
      if (spi_cs_n && spi_sck) idle_bad++;
      if (!sck_q && spi_sck) begin rises++; seen_rise = 1'b1; end
      if (!spi_cs_n && !spi_sck && !seen_rise) pre_rise++;
      if (spi_sck) hi_run++;
      else if (sck_q) begin
        last_hi = hi_run;
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (spi_sck && spi_mosi != mosi_q) mosi_bad++;
      if (rd_valid && rd_ready && n_got < 32) begin got[n_got] = rd_data; n_got++; end
    end
    sck_q = spi_sck; cs_q = spi_cs_n; mosi_q = spi_mosi;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [23:0] a, input int len, input logic fast);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_fast = fast;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [23:0] a, input int len, input logic fast);
    int half;
    half = fast ? FH : NH;
    n_got = 0; rd_ready = 1'b1;
    issue(a, len, fast);
    wait_idle();
    if (fast) begin
      chk(m_op == 8'h0B, "R3 opcode", m_op, 8'h0B);
      chk(m_dummy == 8'h00, "R3 dummy", m_dummy, 0);
      chk(rises == 40 + 8 * len, "R6 rises", rises, 40 + 8 * len);
    end else begin
      chk(m_op == 8'h03, "R2 opcode", m_op, 8'h03);
      chk(rises == 32 + 8 * len, "R6 rises", rises, 32 + 8 * len);
    end
    chk(m_addr == a, "R2 address", m_addr, a);
    chk(n_got == len, "R6 bytes", n_got, len);
    for (int i = 0; i < len && i < 32; i++)
      chk(got[i] == romf(a + 24'(i)), "R2 R7 data", got[i], romf(a + 24'(i)));
    chk(hi_min == half && hi_max == half, "R5 high phase", hi_max, half);
    chk(pre_rise == half, "R8 setup", pre_rise, half);
    chk(last_hi == half, "R11 tail", last_hi, half);
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R1 cs", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
  endtask

  task automatic t_stall();
    logic [7:0] snap;
    n_got = 0; rd_ready = 1'b0;
    issue(24'h000100, 3, 1'b0);
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
    snap = rd_data;
    repeat (300) @(negedge clk);
    chk(rises == 32 + 15, "R9 clock held", rises, 47);
    chk(spi_sck == 1'b0 && spi_cs_n == 1'b0, "R9 sck low", spi_sck, 0);
    chk(rd_valid && rd_data == snap && snap == romf(24'h000100), "R9 data kept", rd_data, romf(24'h000100));
    rd_ready = 1'b1;
    wait_idle();
    chk(n_got == 3, "R9 bytes", n_got, 3);
    for (int i = 0; i < 3; i++)
      chk(got[i] == romf(24'h000100 + 24'(i)), "R9 no loss", got[i], romf(24'h000100 + 24'(i)));
  endtask

  task automatic t_refuse();
    int s0;
    s0 = sess; n_got = 0; rd_ready = 1'b1;
    issue(24'h00ABCD, 2, 1'b0);
    repeat (20) @(posedge clk);
    issue(24'h777777, 9, 1'b1);
    wait_idle();
    repeat (30) @(negedge clk);
    chk(sess == s0 + 1, "R10 one session", sess - s0, 1);
    chk(m_addr == 24'h00ABCD && n_got == 2, "R10 refused", m_addr, 24'h00ABCD);
    chk(spi_cs_n == 1'b1 && !busy, "R10 idle after", busy, 0);
    s0 = sess;
    issue(24'h000010, 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(sess == s0 && !busy && spi_cs_n, "R6 zero length", sess - s0, 0);
  endtask

  task automatic t_back_to_back();
    issue(24'h001000, 1, 1'b1);
    @(negedge clk);
    while (busy) @(negedge clk);
    do_read(24'h002000, 1, 1'b1);
    chk(gap_min >= GAP, "R10 gap", gap_min, GAP);
    chk(mosi_bad == 0 && idle_bad == 0, "R4 mode0", mosi_bad + idle_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual=%0d expected<%0d", 150000, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_read(24'h012345, 4, 1'b0);
    do_read(24'h0F00A0, 5, 1'b1);
    do_read(24'hFFFFFE, 3, 1'b1);
    do_read(24'hFFFFFF, 2, 1'b0);
    t_stall();
    t_refuse();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule